// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

This peripheral holds two independent down-counters that step once per clock of a shared timer clock. Each counter has a value register that software loads directly and a reload register that refills the counter when it expires. One shared control word carries, for each counter, a run bit and an auto-reload bit. With both bits set the counter is periodic: loading value and reload with N-1 yields one expiry every N clocks. Loading all ones into both makes a free-running source with the full wrap period, which software can invert to get a rising count. With auto-reload cleared the counter is a one-shot: it expires once and then rests at zero.

An expiry sets a sticky per-counter bit in a shared cause register. Software clears a cause bit by writing 0 to it and leaves it alone by writing 1. A mask register gates each cause bit onto its own interrupt pin. A masked expiry still records its cause bit.

Software reaches the registers through a simple request port. A request is accepted in the cycle `req_valid_i` is high. There is no ready signal and no back-pressure, because every request completes in one cycle. A read returns its data on `rd_data_o` one cycle later, flagged by `rd_valid_o`. The response has no back-pressure either, so the requester must take it in that cycle.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every register reads 0, both counters are stopped and both interrupt pins are low.
- R2: The control word sits at offset 0x000. Counter t uses bit 2t as its run bit and bit 2t+1 as its auto-reload bit. Bits above 3 read as 0.
- R3: A running counter with a nonzero value drops by exactly one on each clock. A counter whose run bit is 0 keeps its value.
- R4: A running counter at 0 with auto-reload set loads its reload register on the next clock. Value and reload both at N-1 give one expiry every N clocks.
- R5: A running counter at 0 with auto-reload clear stays at 0. This one-shot mode therefore expires exactly once per load.
- R6: A write to a value register loads the counter on that edge, replacing any decrement. No expiry is raised on that edge.
- R7: A running counter that steps from 1 to 0 sets its cause bit on that same edge, whatever its mask bit is. Counter 0 uses cause bit 1 and counter 1 uses cause bit 2.
- R8: A write to the cause register clears each bit written as 0 and keeps each bit written as 1. An expiry on the same edge as a clear leaves the bit set.
- R9: Interrupt pin t is high exactly when cause bit t+1 and mask bit t+1 are both 1. The mask register is at offset 0x114.
- R10: Offsets are: reload 0 at 0x010, value 0 at 0x014, reload 1 at 0x018, value 1 at 0x01C, cause at 0x110. Read data appears one cycle after the request. Other offsets read as 0 and ignore writes.
- R11: All ones in value and reload, with run and auto-reload set, gives a free-running counter. It visits every value, and its expiries are 2^CNT_W clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle; always accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rd_data_o | output | 32 | Read data, counter fields zero-extended |
| irq_o | output | 2 | Per-counter interrupt, cause AND mask |

## Verification
The bench builds the block with CNT_W = 8 and keeps the 32-bit data path and 12-bit offsets. With that width a full free-running wrap takes only 256 clocks, so R11's complete period and the truncation of wide write data into the counters can both be observed within a short run. Smaller widths would not change the register map. Periodic, one-shot, collision and masking behaviour are all compared clock by clock against a behavioural model.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned NUM_TMR    = 2;
  localparam int unsigned ADDR_W     = 12;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned CAUSE_BASE = 1;
  localparam int unsigned TMR_STRIDE = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_RLD   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_VAL   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_CAUSE = 12'h110;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h114;

  typedef struct packed {
    logic reload;
    logic run;
  } tmr_ctl_t;

  function automatic logic [ADDR_W-1:0] rld_off(int unsigned t);
    return OFF_RLD + ADDR_W'(t * TMR_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] val_off(int unsigned t);
    return OFF_VAL + ADDR_W'(t * TMR_STRIDE);
  endfunction

  function automatic int unsigned cause_pos(int unsigned t);
    return t + CAUSE_BASE;
  endfunction

  function automatic int unsigned run_pos(int unsigned t);
    return 2 * t;
  endfunction

  function automatic int unsigned reload_pos(int unsigned t);
    return 2 * t + 1;
  endfunction
endpackage

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             reload_en_i,
  input  logic [CNT_W-1:0] rld_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero  = (cnt_q == ZERO);
  assign expire_o = run_i && !ld_i && (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (run_i) begin
      if (!at_zero)         cnt_d = cnt_q - ONE;
      else if (reload_en_i) cnt_d = rld_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= ZERO;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dtmr_regfile.sv
module dtmr_regfile
  import dtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  input  logic                           req_write_i,
  input  logic [ADDR_W-1:0]              req_addr_i,
  input  logic [DATA_W-1:0]              req_wdata_i,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]  cnt_i,
  input  logic [NUM_TMR-1:0]             expire_i,
  output tmr_ctl_t [NUM_TMR-1:0]         ctl_o,
  output logic [NUM_TMR-1:0][CNT_W-1:0]  rld_o,
  output logic [NUM_TMR-1:0]             val_ld_o,
  output logic [CNT_W-1:0]               ld_val_o,
  output logic [NUM_TMR-1:0]             cause_o,
  output logic [NUM_TMR-1:0]             mask_o,
  output logic                           rd_valid_o,
  output logic [DATA_W-1:0]              rd_data_o
);
  logic wr_go, rd_go;
  logic hit_ctrl, hit_cause, hit_mask;
  logic [NUM_TMR-1:0] hit_rld, hit_val;

  tmr_ctl_t [NUM_TMR-1:0]        ctl_q;
  logic [NUM_TMR-1:0][CNT_W-1:0] rld_q;
  logic [NUM_TMR-1:0]            cause_q, mask_q;
  logic                          rd_valid_q;
  logic [DATA_W-1:0]             rd_data_q, rdata_c;

  assign wr_go     = req_valid_i && req_write_i;
  assign rd_go     = req_valid_i && !req_write_i;
  assign hit_ctrl  = (req_addr_i == OFF_CTRL);
  assign hit_cause = (req_addr_i == OFF_CAUSE);
  assign hit_mask  = (req_addr_i == OFF_MASK);
  assign ld_val_o  = CNT_W'(req_wdata_i);

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign hit_rld[t]  = (req_addr_i == rld_off(t));
    assign hit_val[t]  = (req_addr_i == val_off(t));
    assign val_ld_o[t] = wr_go && hit_val[t];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_q[t]   <= '0;
        rld_q[t]   <= '0;
        mask_q[t]  <= 1'b0;
        cause_q[t] <= 1'b0;
      end else begin
        if (wr_go && hit_ctrl) begin
          ctl_q[t].run    <= req_wdata_i[run_pos(t)];
          ctl_q[t].reload <= req_wdata_i[reload_pos(t)];
        end
        if (wr_go && hit_rld[t]) rld_q[t] <= CNT_W'(req_wdata_i);
        if (wr_go && hit_mask)   mask_q[t] <= req_wdata_i[cause_pos(t)];
        // expiry wins over a same-edge software clear
        cause_q[t] <= expire_i[t] ||
                      (cause_q[t] && !(wr_go && hit_cause && !req_wdata_i[cause_pos(t)]));
      end
    end
  end

  always_comb begin
    rdata_c = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (hit_ctrl) begin
        rdata_c[run_pos(t)]    = ctl_q[t].run;
        rdata_c[reload_pos(t)] = ctl_q[t].reload;
      end
      if (hit_rld[t]) rdata_c = DATA_W'(rld_q[t]);
      if (hit_val[t]) rdata_c = DATA_W'(cnt_i[t]);
      if (hit_cause)  rdata_c[cause_pos(t)] = cause_q[t];
      if (hit_mask)   rdata_c[cause_pos(t)] = mask_q[t];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_go;
      if (rd_go) rd_data_q <= rdata_c;
    end
  end

  assign ctl_o      = ctl_q;
  assign rld_o      = rld_q;
  assign cause_o    = cause_q;
  assign mask_o     = mask_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import dtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rd_valid_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [NUM_TMR-1:0] irq_o
);
  tmr_ctl_t [NUM_TMR-1:0]        ctl_w;
  logic [NUM_TMR-1:0][CNT_W-1:0] rld_w, cnt_w;
  logic [NUM_TMR-1:0]            val_ld_w, expire_w, cause_w, mask_w;
  logic [CNT_W-1:0]              ld_val_w;

  dtmr_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .cnt_i       (cnt_w),
    .expire_i    (expire_w),
    .ctl_o       (ctl_w),
    .rld_o       (rld_w),
    .val_ld_o    (val_ld_w),
    .ld_val_o    (ld_val_w),
    .cause_o     (cause_w),
    .mask_o      (mask_w),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_cnt
    dtmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (ctl_w[t].run),
      .reload_en_i (ctl_w[t].reload),
      .rld_i       (rld_w[t]),
      .ld_i        (val_ld_w[t]),
      .ld_val_i    (ld_val_w),
      .cnt_o       (cnt_w[t]),
      .expire_o    (expire_w[t])
    );
  end

  assign irq_o = cause_w & mask_w;
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
  import dtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_valid_i,
  input logic                          req_write_i,
  input logic [ADDR_W-1:0]             req_addr_i,
  input logic [DATA_W-1:0]             req_wdata_i,
  input logic                          rd_valid_o,
  input logic [NUM_TMR-1:0]            irq_o,
  input tmr_ctl_t [NUM_TMR-1:0]        ctl_w,
  input logic [NUM_TMR-1:0][CNT_W-1:0] rld_w,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_w,
  input logic [NUM_TMR-1:0]            val_ld_w,
  input logic [NUM_TMR-1:0]            cause_w,
  input logic [NUM_TMR-1:0]            mask_w
);
  logic rd_req, cause_wr;
  assign rd_req   = req_valid_i && !req_write_i;
  assign cause_wr = req_valid_i && req_write_i && (req_addr_i == OFF_CAUSE);

  p_rd_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rd_valid_o);
  p_rd_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rd_valid_o);

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
    p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_w[t].run && !val_ld_w[t] && cnt_w[t] != '0) |=> cnt_w[t] == $past(cnt_w[t]) - 1'b1);
    p_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctl_w[t].run && !val_ld_w[t]) |=> $stable(cnt_w[t]));
    p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_w[t].run && ctl_w[t].reload && !val_ld_w[t] && cnt_w[t] == '0) |=> cnt_w[t] == $past(rld_w[t]));
    p_oneshot_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_w[t].run && !ctl_w[t].reload && !val_ld_w[t] && cnt_w[t] == '0) |=> cnt_w[t] == '0);
    p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      val_ld_w[t] |=> cnt_w[t] == CNT_W'($past(req_wdata_i)));
    p_expire_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_w[t].run && !val_ld_w[t] && cnt_w[t] == CNT_W'(1)) |=> cause_w[t]);
    p_cause_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cause_w[t] && !cause_wr) |=> cause_w[t]);
    p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[t] |-> (mask_w[t] && cause_w[t]));
  end
endmodule

bind dual_down_timer dtmr_checker #(.CNT_W(CNT_W)) u_dtmr_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .rd_valid_o  (rd_valid_o),
  .irq_o       (irq_o),
  .ctl_w       (ctl_w),
  .rld_w       (rld_w),
  .cnt_w       (cnt_w),
  .val_ld_w    (val_ld_w),
  .cause_w     (cause_w),
  .mask_w      (mask_w)
);

// File: tb/dual_down_timer_bench.sv
`timescale 1ns/1ps
module dual_down_timer_bench;
  localparam int CW    = 8;
  localparam int CMASK = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [1:0]  irq;

  dual_down_timer #(.CNT_W(CW)) u_dual_down_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  always #5 clk = ~clk;

  int    n_checks = 0, n_errors = 0;
  string cur_tag = "R1";
  bit    finished = 1'b0;

  // behavioural reference state
  int m_cnt[2], m_rld[2];
  int m_ctrl, m_cause, m_mask;
  bit exp_rv;
  int exp_rd;
  int wr_n, rd_n;
  int exp_irq;

  function automatic int mread(int a);
    case (a)
      'h000: return m_ctrl;
      'h010: return m_rld[0];
      'h014: return m_cnt[0];
      'h018: return m_rld[1];
      'h01C: return m_cnt[1];
      'h110: return m_cause;
      'h114: return m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '{0, 0}; m_rld = '{0, 0};
      m_ctrl = 0; m_cause = 0; m_mask = 0; exp_rv = 0; exp_rd = 0;
    end else begin
      wr_n = req_valid && req_write;
      rd_n = req_valid && !req_write;
      exp_rv = rd_n;
      if (rd_n) exp_rd = mread(int'(req_addr));
      for (int t = 0; t < 2; t++) begin
        bit run, rel, ld, fire;
        run  = (m_ctrl >> (2*t)) & 1;
        rel  = (m_ctrl >> (2*t+1)) & 1;
        ld   = wr_n && (int'(req_addr) == 'h14 + 8*t);
        fire = run && !ld && (m_cnt[t] == 1);
        if (ld) m_cnt[t] = int'(req_wdata) & CMASK;
        else if (run && m_cnt[t] != 0) m_cnt[t] = m_cnt[t] - 1;
        else if (run && rel) m_cnt[t] = m_rld[t];
        if (wr_n && int'(req_addr) == 'h110 && req_wdata[t+1] == 1'b0)
          m_cause = m_cause & ~(1 << (t+1));
        if (fire) m_cause = m_cause | (1 << (t+1));
      end
      if (wr_n) begin
        case (int'(req_addr))
          'h000: m_ctrl = int'(req_wdata) & 'hF;
          'h010: m_rld[0] = int'(req_wdata) & CMASK;
          'h018: m_rld[1] = int'(req_wdata) & CMASK;
          'h114: m_mask = int'(req_wdata) & 'h6;
          default: ;
        endcase
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      exp_irq = (m_cause & m_mask) >> 1;
      chk(int'(irq) == exp_irq, rst_n ? "R9" : "R1", "irq pins", int'(irq), exp_irq);
      if (rst_n) begin
        chk(rd_valid == exp_rv, "R10", "read valid", int'(rd_valid), int'(exp_rv));
        if (exp_rv && rd_valid)
          chk(int'(rd_data) == exp_rd, cur_tag, "read data", int'(rd_data), exp_rd);
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 12'(a); req_wdata = 32'(d);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(int a);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 12'(a);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_all();
    rd('h000); rd('h010); rd('h014); rd('h018); rd('h01C); rd('h110); rd('h114);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    cur_tag = "R1"; read_all();

    cur_tag = "R2"; wr('h000, 'hFFFF_FFF0); rd('h000);
    wr('h000, 'h0000_0000); rd('h000);
    cur_tag = "R10"; wr('h004, 'h55); wr('h200, 'h77); rd('h004); rd('h200); read_all();
    wr('h010, 'h1234_56A5); rd('h010);

    cur_tag = "R3"; wr('h014, 40); wr('h000, 'h1); idle(6); rd('h014);
    wr('h000, 'h0); idle(4); rd('h014); rd('h014);

    cur_tag = "R6"; wr('h000, 'h1); wr('h014, 9); rd('h014);
    wr('h014, 1); wr('h014, 1); wr('h014, 7); rd('h110);

    cur_tag = "R5"; wr('h110, 0); wr('h000, 'h4); wr('h01C, 3); idle(10);
    rd('h01C); rd('h110); idle(5); rd('h01C);

    cur_tag = "R7"; wr('h114, 'h0); wr('h110, 0); wr('h000, 'h1); wr('h014, 2);
    idle(4); rd('h110); wr('h114, 'h2); idle(2);

    cur_tag = "R8"; wr('h110, 'h6); rd('h110); wr('h110, 'h4); rd('h110);
    wr('h000, 'h1); wr('h014, 3); idle(2); wr('h110, 'h0); rd('h110);
    wr('h110, 'h0); rd('h110);

    cur_tag = "R4"; wr('h000, 'h0); wr('h114, 'h6); wr('h018, 4); wr('h01C, 4);
    wr('h000, 'hC);
    for (int k = 0; k < 6; k++) begin
      idle(3); wr('h110, 'h2); rd('h01C);
    end
    wr('h018, 0); idle(8); rd('h01C); rd('h110);

    cur_tag = "R11"; wr('h000, 'h0); wr('h110, 0); wr('h010, 'hFFFF_FFFF);
    wr('h014, 'hFFFF_FFFF); wr('h000, 'h3);
    for (int k = 0; k < 5; k++) begin
      idle(120); rd('h014); rd('h110); wr('h110, 0);
    end

    cur_tag = "R9"; wr('h114, 'h0); idle(300); wr('h114, 'h6); idle(4); rd('h114);
    idle(2);
    finish_run();
  end
endmodule